// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits on the receive path between a MAC byte stream and a receive FIFO. It watches each frame as it streams past, counts its bytes, collects the error and overlap conditions that occur during the frame, and decides at the last byte whether the frame is kept, discarded or kept with a long tag. Bytes go to the FIFO one cycle after they arrive. When the frame ends, a status word reports the length, the error, long and runt tags, and whether the frame was accepted or must be dropped. The FIFO discards a dropped frame using the drop flag.

Four policy inputs control the decision. The first keeps frames that carry errors. The second keeps short frames. The third keeps frames received while the local transmitter is busy, and it also makes the filter ignore collisions. The fourth raises the size limit. All four are captured at the first byte of a frame and hold for that whole frame. Too-long frames are clipped: bytes past the write limit are never written. The write limit is 1518 bytes when long frames are not accepted and 2046 bytes when they are.

A three-state controller tracks each frame. IDLE waits for a start beat. PASS forwards bytes. CLIP swallows bytes past the write limit. Transitions:
- IDLE→PASS on a start beat without end.
- IDLE→IDLE on a single-beat frame (start and end together).
- PASS→IDLE on an end beat.
- PASS→CLIP when the write limit is reached without end.
- CLIP→IDLE on an end beat.

Top module: `rxacc_filter`

## Requirements
- R1: A byte accepted on an input beat appears on `fifo_we`/`fifo_data` exactly one clock later, in arrival order. The status word (`stat_valid` high for one cycle) appears one clock after the end beat.
- R2: An error is a CRC error, an alignment error, or a collision when `cfg_acc_tx`=0. When `cfg_acc_err`=0, a frame with an error has `stat_err`=1 and `stat_drop`=1. When `cfg_acc_err`=1, the same frame has `stat_err`=1 and `stat_accept`=1.
- R3: A frame of fewer than 64 bytes has `stat_runt`=1. If it carries no error, it is dropped when `cfg_acc_runt`=0 and accepted when `cfg_acc_runt`=1. A 64-byte frame is not a runt.
- R4: A frame that is both a runt and errored is accepted only when `cfg_acc_err` and `cfg_acc_runt` are both 1.
- R5: With `cfg_acc_long`=0, a frame of up to 1518 bytes is normal. A frame longer than that has at most 1518 bytes written, reports `stat_len`=1514, and has `stat_long`=1 and `stat_drop`=1.
- R6: With `cfg_acc_long`=1, frames of 1519 to 2046 bytes are accepted with `stat_long`=0 and the full length.
- R7: With `cfg_acc_long`=1, a frame longer than 2046 bytes has exactly 2046 bytes written, `stat_len`=2046, `stat_long`=1 and `stat_accept`=1.
- R8: A frame with `tx_active` high on any of its beats is dropped when `cfg_acc_tx`=0. When `cfg_acc_tx`=1, the frame is accepted and a collision flag does not count as an error.
- R9: The four policy inputs are sampled on the start beat. Changes during the frame do not affect that frame's decision.
- R10: Beats received while IDLE without `in_sof` write nothing and produce no status.
- R11: A beat with `in_sof` and `in_eof` both high is a complete one-byte frame: one write and one status with `stat_len`=1 and `stat_runt`=1.
- R12: `stat_accept` and `stat_drop` are complementary whenever `stat_valid` is high. Otherwise all outputs stay low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_acc_err | input | 1 | Keep frames that carry errors |
| cfg_acc_runt | input | 1 | Keep frames shorter than 64 bytes |
| cfg_acc_tx | input | 1 | Keep frames overlapping local transmit; ignore collisions |
| cfg_acc_long | input | 1 | Raise the size limit to 2046 bytes |
| tx_active | input | 1 | Local transmitter busy |
| in_valid | input | 1 | Input byte beat valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Received byte |
| in_err_crc | input | 1 | CRC error seen on this beat |
| in_err_align | input | 1 | Alignment error seen on this beat |
| in_err_coll | input | 1 | Collision seen on this beat |
| fifo_we | output | 1 | FIFO write enable |
| fifo_data | output | 8 | FIFO write byte |
| stat_valid | output | 1 | End-of-frame status valid |
| stat_len | output | 12 | Reported frame length |
| stat_err | output | 1 | Frame counted as errored |
| stat_long | output | 1 | Frame over the size limit |
| stat_runt | output | 1 | Frame under 64 bytes |
| stat_accept | output | 1 | Frame is kept |
| stat_drop | output | 1 | Frame must be discarded |

## Verification
The checker relies on a well-formed input stream. `in_sof` rises only on the first beat of a frame, never while a frame is open, and every frame ends with an `in_eof` beat. On that basis it keeps its own copy of the policy bits captured at each start beat. The bench keeps within this by building every frame through one task. That task raises start only on beat zero and end only on the final beat. Stray mid-stream beats are sent only while no frame is open.

// File: rtl/rxacc_pkg.sv
package rxacc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_CLIP = 2'd2
    } rxacc_state_e;

    typedef struct packed {
        logic acc_err;
        logic acc_runt;
        logic acc_tx;
        logic acc_long;
    } rxacc_cfg_t;

    typedef struct packed {
        logic crc;
        logic align;
        logic coll;
        logic tx;
    } rxacc_flags_t;

endpackage

// File: rtl/rxacc_len_ctr.sv
module rxacc_len_ctr #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    output logic [LEN_W-1:0] cnt_next
);
    localparam logic [LEN_W-1:0] CNT_TOP = '1;

    logic [LEN_W-1:0] cnt_q;

    // Count including the current beat; saturates at the counter ceiling.
    always_comb begin
        if (restart)
            cnt_next = LEN_W'(1);
        else if (cnt_q == CNT_TOP)
            cnt_next = CNT_TOP;
        else
            cnt_next = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_next;
    end
endmodule

// File: rtl/rxacc_judge.sv
module rxacc_judge
    import rxacc_pkg::*;
#(
    parameter int LEN_W   = 12,
    parameter int MIN_LEN = 64,
    parameter int STD_MAX = 1518,
    parameter int STD_CUT = 1514,
    parameter int EXT_MAX = 2046
) (
    input  rxacc_cfg_t       cfg,
    input  rxacc_flags_t     flags,
    input  logic [LEN_W-1:0] rx_len,
    output logic [LEN_W-1:0] wr_limit,
    output logic [LEN_W-1:0] rep_len,
    output logic             is_err,
    output logic             is_long,
    output logic             is_runt,
    output logic             accept
);
    localparam logic [LEN_W-1:0] LIM_MIN = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LIM_STD = LEN_W'(STD_MAX);
    localparam logic [LEN_W-1:0] LEN_CUT = LEN_W'(STD_CUT);
    localparam logic [LEN_W-1:0] LIM_EXT = LEN_W'(EXT_MAX);

    logic tx_reject;
    logic err_ok;
    logic runt_ok;
    logic long_ok;

    always_comb begin
        wr_limit  = cfg.acc_long ? LIM_EXT : LIM_STD;
        is_long   = cfg.acc_long ? (rx_len > LIM_EXT) : (rx_len > LIM_STD);
        is_runt   = rx_len < LIM_MIN;
        if (cfg.acc_long)
            rep_len = is_long ? LIM_EXT : rx_len;
        else
            rep_len = is_long ? LEN_CUT : rx_len;

        // Collisions count as errors only while transmit overlap is not accepted.
        is_err    = flags.crc | flags.align | (flags.coll & ~cfg.acc_tx);
        tx_reject = flags.tx & ~cfg.acc_tx;
        err_ok    = ~is_err  | cfg.acc_err;
        runt_ok   = ~is_runt | cfg.acc_runt;
        long_ok   = ~is_long | cfg.acc_long;
        accept    = ~tx_reject & err_ok & runt_ok & long_ok;
    end
endmodule

// File: rtl/rxacc_filter.sv
module rxacc_filter
    import rxacc_pkg::*;
#(
    parameter int LEN_W   = 12,
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 64,
    parameter int STD_MAX = 1518,
    parameter int STD_CUT = 1514,
    parameter int EXT_MAX = 2046
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_acc_err,
    input  logic              cfg_acc_runt,
    input  logic              cfg_acc_tx,
    input  logic              cfg_acc_long,
    input  logic              tx_active,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_err_crc,
    input  logic              in_err_align,
    input  logic              in_err_coll,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_data,
    output logic              stat_valid,
    output logic [LEN_W-1:0]  stat_len,
    output logic              stat_err,
    output logic              stat_long,
    output logic              stat_runt,
    output logic              stat_accept,
    output logic              stat_drop
);
    rxacc_state_e     state_q, state_d;
    rxacc_cfg_t       cfg_q, cfg_live, cfg_eff;
    rxacc_flags_t     flags_q, flags_beat, flags_eff;

    logic             in_frame;
    logic             beat;
    logic             start;
    logic [LEN_W-1:0] len_now;
    logic [LEN_W-1:0] wr_limit;
    logic [LEN_W-1:0] rep_len;
    logic             j_err, j_long, j_runt, j_accept;

    assign in_frame = (state_q != ST_IDLE);
    assign beat     = in_valid & (in_frame | in_sof);
    assign start    = in_valid & in_sof & ~in_frame;

    always_comb begin
        cfg_live   = '{acc_err: cfg_acc_err, acc_runt: cfg_acc_runt,
                       acc_tx: cfg_acc_tx, acc_long: cfg_acc_long};
        flags_beat = '{crc: in_err_crc, align: in_err_align,
                       coll: in_err_coll, tx: tx_active};
        cfg_eff    = start ? cfg_live : cfg_q;
        flags_eff  = (start ? '0 : flags_q) | flags_beat;
    end

    rxacc_len_ctr #(
        .LEN_W (LEN_W)
    ) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (beat),
        .restart  (start),
        .cnt_next (len_now)
    );

    rxacc_judge #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN),
        .STD_MAX (STD_MAX),
        .STD_CUT (STD_CUT),
        .EXT_MAX (EXT_MAX)
    ) u_judge (
        .cfg      (cfg_eff),
        .flags    (flags_eff),
        .rx_len   (len_now),
        .wr_limit (wr_limit),
        .rep_len  (rep_len),
        .is_err   (j_err),
        .is_long  (j_long),
        .is_runt  (j_runt),
        .accept   (j_accept)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && !in_eof)
                    state_d = ST_PASS;
            end
            ST_PASS: begin
                if (in_valid && in_eof)
                    state_d = ST_IDLE;
                else if (in_valid && (len_now >= wr_limit))
                    state_d = ST_CLIP;
            end
            ST_CLIP: begin
                if (in_valid && in_eof)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and per-frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            if (start)
                cfg_q <= cfg_live;
            if (beat)
                flags_q <= flags_eff;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_we     <= 1'b0;
            fifo_data   <= '0;
            stat_valid  <= 1'b0;
            stat_len    <= '0;
            stat_err    <= 1'b0;
            stat_long   <= 1'b0;
            stat_runt   <= 1'b0;
            stat_accept <= 1'b0;
            stat_drop   <= 1'b0;
        end else begin
            fifo_we    <= beat && (state_q != ST_CLIP) && (len_now <= wr_limit);
            fifo_data  <= in_data;
            stat_valid <= beat && in_eof;
            if (beat && in_eof) begin
                stat_len    <= rep_len;
                stat_err    <= j_err;
                stat_long   <= j_long;
                stat_runt   <= j_runt;
                stat_accept <= j_accept;
                stat_drop   <= ~j_accept;
            end else begin
                stat_len    <= '0;
                stat_err    <= 1'b0;
                stat_long   <= 1'b0;
                stat_runt   <= 1'b0;
                stat_accept <= 1'b0;
                stat_drop   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxacc_filter_chk.sv
module rxacc_filter_chk #(
    parameter int LEN_W   = 12,
    parameter int MIN_LEN = 64,
    parameter int STD_MAX = 1518,
    parameter int STD_CUT = 1514,
    parameter int EXT_MAX = 2046
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic             in_eof,
    input logic             cfg_acc_err,
    input logic             cfg_acc_runt,
    input logic             cfg_acc_long,
    input logic             fifo_we,
    input logic             stat_valid,
    input logic [LEN_W-1:0] stat_len,
    input logic             stat_err,
    input logic             stat_long,
    input logic             stat_runt,
    input logic             stat_accept,
    input logic             stat_drop
);
    logic ck_open;
    logic ck_err, ck_runt, ck_long;

    // Independent record of the policy captured at each start beat.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_open <= 1'b0;
            ck_err  <= 1'b0;
            ck_runt <= 1'b0;
            ck_long <= 1'b0;
        end else if (in_valid) begin
            if (in_sof && !ck_open) begin
                ck_err  <= cfg_acc_err;
                ck_runt <= cfg_acc_runt;
                ck_long <= cfg_acc_long;
                ck_open <= !in_eof;
            end else if (ck_open && in_eof) begin
                ck_open <= 1'b0;
            end
        end
    end

    assert_write_follows_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we |-> $past(in_valid));

    assert_status_follows_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(in_valid && in_eof));

    assert_err_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_err && !ck_err) |-> stat_drop);

    assert_runt_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_runt) |-> (stat_len < LEN_W'(MIN_LEN)));

    assert_runt_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_runt && !ck_runt) |-> stat_drop);

    assert_std_long_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_long && !ck_long) |-> (stat_drop && stat_len == LEN_W'(STD_CUT)));

    assert_ext_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && ck_long) |-> (stat_len <= LEN_W'(EXT_MAX)));

    assert_std_len_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !ck_long) |-> (stat_len <= LEN_W'(STD_MAX)));

    assert_ext_long_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && ck_long && !stat_long) |-> (stat_len <= LEN_W'(EXT_MAX)));

    assert_verdict_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $onehot({stat_accept, stat_drop}));

    assert_quiet_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_valid |-> !(stat_accept || stat_drop || stat_err || stat_long || stat_runt));
endmodule

bind rxacc_filter rxacc_filter_chk #(
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN),
    .STD_MAX (STD_MAX),
    .STD_CUT (STD_CUT),
    .EXT_MAX (EXT_MAX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sof       (in_sof),
    .in_eof       (in_eof),
    .cfg_acc_err  (cfg_acc_err),
    .cfg_acc_runt (cfg_acc_runt),
    .cfg_acc_long (cfg_acc_long),
    .fifo_we      (fifo_we),
    .stat_valid   (stat_valid),
    .stat_len     (stat_len),
    .stat_err     (stat_err),
    .stat_long    (stat_long),
    .stat_runt    (stat_runt),
    .stat_accept  (stat_accept),
    .stat_drop    (stat_drop)
);

// File: tb/test_rxacc_filter.sv
`timescale 1ns/1ps
module test_rxacc_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_acc_err = 1'b0, cfg_acc_runt = 1'b0, cfg_acc_tx = 1'b0, cfg_acc_long = 1'b0;
    logic        tx_active = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_err_crc = 1'b0, in_err_align = 1'b0, in_err_coll = 1'b0;
    logic        fifo_we;
    logic [7:0]  fifo_data;
    logic        stat_valid;
    logic [11:0] stat_len;
    logic        stat_err, stat_long, stat_runt, stat_accept, stat_drop;

    int checks = 0;
    int errors = 0;

    // Results of the last frame
    int  we_cnt, data_bad, stat_cnt, stat_pos, sample_idx, exp_byte, last_len;
    int  s_len;
    bit  s_err, s_long, s_runt, s_acc, s_drop;

    always #4 clk = ~clk;

    rxacc_filter i_rxacc_filter (
        .clk (clk), .rst_n (rst_n),
        .cfg_acc_err (cfg_acc_err), .cfg_acc_runt (cfg_acc_runt),
        .cfg_acc_tx (cfg_acc_tx), .cfg_acc_long (cfg_acc_long),
        .tx_active (tx_active),
        .in_valid (in_valid), .in_sof (in_sof), .in_eof (in_eof), .in_data (in_data),
        .in_err_crc (in_err_crc), .in_err_align (in_err_align), .in_err_coll (in_err_coll),
        .fifo_we (fifo_we), .fifo_data (fifo_data),
        .stat_valid (stat_valid), .stat_len (stat_len), .stat_err (stat_err),
        .stat_long (stat_long), .stat_runt (stat_runt),
        .stat_accept (stat_accept), .stat_drop (stat_drop)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] c);
        {cfg_acc_err, cfg_acc_runt, cfg_acc_tx, cfg_acc_long} = c;
    endtask

    task automatic sample();
        if (fifo_we) begin
            if (fifo_data != exp_byte[7:0]) data_bad++;
            exp_byte++;
            we_cnt++;
        end
        if (stat_valid) begin
            stat_cnt++;
            stat_pos = sample_idx;
            s_len  = int'(stat_len);
            s_err  = stat_err;  s_long = stat_long; s_runt = stat_runt;
            s_acc  = stat_accept; s_drop = stat_drop;
        end
        sample_idx++;
    endtask

    // cfg bits: {acc_err, acc_runt, acc_tx, acc_long}; errors flagged on the last beat
    task automatic run_frame(input int len, input logic [3:0] cfg_a, input logic [3:0] cfg_b,
                             input int flip_at, input logic crc, input logic aln,
                             input logic col, input int tx_at);
        we_cnt = 0; data_bad = 0; stat_cnt = 0; stat_pos = -1; sample_idx = 0;
        exp_byte = 0; last_len = len;
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            sample();
            set_cfg((flip_at >= 0 && b >= flip_at) ? cfg_b : cfg_a);
            in_valid     = 1'b1;
            in_sof       = (b == 0);
            in_eof       = (b == len - 1);
            in_data      = b[7:0];
            in_err_crc   = crc && (b == len - 1);
            in_err_align = aln && (b == len - 1);
            in_err_coll  = col && (b == len - 1);
            tx_active    = (b == tx_at);
        end
        @(negedge clk);
        sample();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_err_crc = 1'b0; in_err_align = 1'b0; in_err_coll = 1'b0; tx_active = 1'b0;
        @(negedge clk);
        sample();
    endtask

    task automatic check_frame(input string tag, input int e_we, input int e_len,
                               input bit e_err, input bit e_long, input bit e_runt, input bit e_acc);
        chk(stat_cnt == 1, tag, "status count", stat_cnt, 1);
        chk(stat_pos == last_len, tag, "status cycle", stat_pos, last_len);
        chk(we_cnt == e_we, tag, "bytes written", we_cnt, e_we);
        chk(data_bad == 0, tag, "byte order mismatches", data_bad, 0);
        chk(s_len == e_len, tag, "stat_len", s_len, e_len);
        chk(s_err == e_err, tag, "stat_err", s_err, e_err);
        chk(s_long == e_long, tag, "stat_long", s_long, e_long);
        chk(s_runt == e_runt, tag, "stat_runt", s_runt, e_runt);
        chk(s_acc == e_acc, tag, "stat_accept", s_acc, e_acc);
        chk(s_drop == !e_acc, tag, "stat_drop", s_drop, !e_acc);
    endtask

    task automatic t_reset();
        chk(!fifo_we && !stat_valid && !stat_accept && !stat_drop, "R12", "outputs after reset",
            {fifo_we, stat_valid, stat_accept, stat_drop}, 0);
    endtask

    task automatic t_normal();
        run_frame(100, 4'b0000, 4'b0000, -1, 0, 0, 0, -1);
        check_frame("R1", 100, 100, 0, 0, 0, 1);
    endtask

    task automatic t_errored();
        run_frame(200, 4'b0000, 4'b0000, -1, 1, 0, 0, -1);
        check_frame("R2 crc reject", 200, 200, 1, 0, 0, 0);
        run_frame(200, 4'b1000, 4'b0000, -1, 1, 0, 0, -1);
        check_frame("R2 crc keep", 200, 200, 1, 0, 0, 1);
        run_frame(80, 4'b0000, 4'b0000, -1, 0, 1, 0, -1);
        check_frame("R2 align reject", 80, 80, 1, 0, 0, 0);
        run_frame(80, 4'b0000, 4'b0000, -1, 0, 0, 1, -1);
        check_frame("R2 coll reject", 80, 80, 1, 0, 0, 0);
    endtask

    task automatic t_runt();
        run_frame(63, 4'b0000, 4'b0000, -1, 0, 0, 0, -1);
        check_frame("R3 runt reject", 63, 63, 0, 0, 1, 0);
        run_frame(63, 4'b0100, 4'b0000, -1, 0, 0, 0, -1);
        check_frame("R3 runt keep", 63, 63, 0, 0, 1, 1);
        run_frame(64, 4'b0000, 4'b0000, -1, 0, 0, 0, -1);
        check_frame("R3 min size", 64, 64, 0, 0, 0, 1);
    endtask

    task automatic t_err_runt();
        run_frame(40, 4'b1000, 4'b0000, -1, 1, 0, 0, -1);
        check_frame("R4 err only", 40, 40, 1, 0, 1, 0);
        run_frame(40, 4'b0100, 4'b0000, -1, 1, 0, 0, -1);
        check_frame("R4 runt only", 40, 40, 1, 0, 1, 0);
        run_frame(40, 4'b1100, 4'b0000, -1, 1, 0, 0, -1);
        check_frame("R4 both", 40, 40, 1, 0, 1, 1);
    endtask

    task automatic t_std_long();
        run_frame(1518, 4'b0000, 4'b0000, -1, 0, 0, 0, -1);
        check_frame("R5 at limit", 1518, 1518, 0, 0, 0, 1);
        run_frame(1519, 4'b0000, 4'b0000, -1, 0, 0, 0, -1);
        check_frame("R5 over limit", 1518, 1514, 0, 1, 0, 0);
        run_frame(1700, 4'b0000, 4'b0000, -1, 0, 0, 0, -1);
        check_frame("R5 far over", 1518, 1514, 0, 1, 0, 0);
    endtask

    task automatic t_ext_long();
        run_frame(1519, 4'b0001, 4'b0001, -1, 0, 0, 0, -1);
        check_frame("R6 low", 1519, 1519, 0, 0, 0, 1);
        run_frame(2046, 4'b0001, 4'b0001, -1, 0, 0, 0, -1);
        check_frame("R6 top", 2046, 2046, 0, 0, 0, 1);
        run_frame(2047, 4'b0001, 4'b0001, -1, 0, 0, 0, -1);
        check_frame("R7 cut", 2046, 2046, 0, 1, 0, 1);
        run_frame(2100, 4'b0001, 4'b0001, -1, 0, 0, 0, -1);
        check_frame("R7 far cut", 2046, 2046, 0, 1, 0, 1);
    endtask

    task automatic t_tx();
        run_frame(120, 4'b0000, 4'b0000, -1, 0, 0, 0, 10);
        check_frame("R8 overlap reject", 120, 120, 0, 0, 0, 0);
        run_frame(120, 4'b0010, 4'b0010, -1, 0, 0, 1, 10);
        check_frame("R8 overlap keep", 120, 120, 0, 0, 0, 1);
    endtask

    task automatic t_cfg_hold();
        run_frame(30, 4'b0000, 4'b0100, 5, 0, 0, 0, -1);
        check_frame("R9 raise mid", 30, 30, 0, 0, 1, 0);
        run_frame(30, 4'b0100, 4'b0000, 5, 0, 0, 0, -1);
        check_frame("R9 lower mid", 30, 30, 0, 0, 1, 1);
        run_frame(1600, 4'b0000, 4'b0001, 3, 0, 0, 0, -1);
        check_frame("R9 long mid", 1518, 1514, 0, 1, 0, 0);
    endtask

    task automatic t_idle_junk();
        we_cnt = 0; stat_cnt = 0; data_bad = 0; sample_idx = 0; exp_byte = 0;
        set_cfg(4'b1111);
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            sample();
            in_valid = 1'b1; in_sof = 1'b0; in_eof = (b == 3); in_data = 8'hA5;
        end
        @(negedge clk);
        sample();
        in_valid = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        sample();
        chk(we_cnt == 0, "R10", "writes from stray beats", we_cnt, 0);
        chk(stat_cnt == 0, "R10", "status from stray beats", stat_cnt, 0);
    endtask

    task automatic t_single();
        run_frame(1, 4'b0100, 4'b0100, -1, 0, 0, 0, -1);
        check_frame("R11", 1, 1, 0, 0, 1, 1);
        run_frame(1, 4'b0000, 4'b0000, -1, 0, 0, 0, -1);
        check_frame("R11 reject", 1, 1, 0, 0, 1, 0);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_errored();
        t_runt();
        t_err_runt();
        t_std_long();
        t_ext_long();
        t_tx();
        t_cfg_hold();
        t_idle_junk();
        t_single();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule